// File: doc/BRIEF.md
# Serial CRC-8 Frame Checker for Single-Wire Sensor Data

This block checks the integrity of data read from a single-wire sensor bus. It takes one bit per clock enable, least significant bit of the first byte first. It keeps a running 8-bit remainder of the polynomial x^8 + x^5 + x^4 + 1 in its reflected form, starting from zero. A frame is valid when the remainder is zero after the data bits and the stored check byte have all been shifted in. For the 64-bit device identifier, the check byte follows 56 data bits: an 8-bit family code and a 48-bit serial number. For a scratchpad read, eight data bytes are followed by a ninth check byte.

An internal bit counter is set to 64 bits or 72 bits by a frame-kind input. After the last bit of a frame, the block raises a done strobe for one cycle, together with either a pass strobe or a fail strobe. The running remainder and a zero flag stay visible at all times. After 56 identifier bits, the remainder is the check byte the sender should have appended. A synchronous clear restarts both the remainder and the counter. Assembling bytes from the wire and bus timing belong to the surrounding logic.

Top module: `owcrc_frame_checker`

## Requirements
- R1: While reset is asserted, and for the two cycles it takes the internal reset to release, rem_o is 0 and done_o, pass_o and fail_o are 0.
- R2: The remainder changes one cycle after an edge with bit_vld_i high and clear_i low, as follows. Let f = bit_i XOR rem_o[0]. The new rem_o is rem_o shifted right by one, XORed with 8'h8C when f is 1.
- R3: When bit_vld_i and clear_i are both low, rem_o and the bit count keep their values.
- R4: clear_i high sets rem_o and the bit count to zero at the next edge, even when bit_vld_i is high at the same edge.
- R5: zero_o is 1 exactly when rem_o equals 8'h00.
- R6: With frame_sel_i = 0, done_o is high for one cycle, in the cycle after the 64th valid bit is taken. It is low after fewer bits.
- R7: With frame_sel_i = 1, done_o is high for one cycle, in the cycle after the 72nd valid bit is taken. It is low after 64 bits.
- R8: When done_o is high, exactly one of pass_o or fail_o is high. pass_o is high when the remainder after the last bit is zero. Neither strobe is high without done_o.
- R9: After the 56 data bits of an identifier, rem_o holds the check byte for those bits. Shifting that byte in, least significant bit first, returns rem_o to zero and gives a pass.
- R10: After the last bit of a frame, the bit count restarts at zero, so the next frame is counted without a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clear_i | input | 1 | Synchronous restart of remainder and bit count |
| frame_sel_i | input | 1 | Frame kind: 0 = 64-bit identifier, 1 = 72-bit scratchpad; hold stable during a frame |
| bit_vld_i | input | 1 | Bit enable: bit_i is taken at this edge |
| bit_i | input | 1 | Serial data bit, least significant bit of each byte first |
| rem_o | output | 8 | Running remainder |
| zero_o | output | 1 | Remainder is zero |
| done_o | output | 1 | One-cycle end-of-frame strobe |
| pass_o | output | 1 | Frame checked clean (with done_o) |
| fail_o | output | 1 | Frame checked bad (with done_o) |

## Verification
The bench builds the block with its default parameters: frames of 64 and 72 bits and the reflected constant 8'h8C. With these values, every possible single byte can be swept through the remainder update and compared against an arithmetic model. Complete identifier and scratchpad frames are built from a pseudo-random pattern, each with its computed check byte appended. Every such frame must pass, and a copy with one flipped bit must fail. The short frame length also places the counter restart, the strobe timing and a clear on the same edge as a bit all within a few hundred cycles.

// File: rtl/owcrc_pkg.sv
package owcrc_pkg;
  localparam int unsigned CRC_W      = 8;
  localparam logic [7:0]  POLY_REFL  = 8'h8C;
  localparam int unsigned ID_BITS    = 64;
  localparam int unsigned PAD_BITS   = 72;

  typedef enum logic {
    FRAME_ID  = 1'b0,
    FRAME_PAD = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/owcrc_rst_sync.sv
module owcrc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/owcrc_serial_core.sv
module owcrc_serial_core #(
  parameter int unsigned          W    = 8,
  parameter logic [W-1:0]         POLY = 8'h8C
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         bit_vld_i,
  input  logic         bit_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] rem_next_o
);
  logic [W-1:0] rem_q;
  logic [W-1:0] rem_d;
  logic         fb;

  always_comb begin
    fb    = bit_i ^ rem_q[0];
    rem_d = rem_q;
    if (clear_i) begin
      rem_d = '0;
    end else if (bit_vld_i) begin
      rem_d = (rem_q >> 1) ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  assign rem_o      = rem_q;
  assign rem_next_o = rem_d;
endmodule

// File: rtl/owcrc_bit_counter.sv
module owcrc_bit_counter #(
  parameter int unsigned LEN_A = 64,
  parameter int unsigned LEN_B = 72
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic sel_i,
  input  logic bit_vld_i,
  output logic last_o
);
  localparam int unsigned MAXLEN = (LEN_A > LEN_B) ? LEN_A : LEN_B;
  localparam int unsigned CW     = $clog2(MAXLEN + 1);
  localparam logic [CW-1:0] END_A = CW'(LEN_A - 1);
  localparam logic [CW-1:0] END_B = CW'(LEN_B - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] end_cnt;
  logic          at_end;

  always_comb begin
    end_cnt = sel_i ? END_B : END_A;
    at_end  = (cnt_q == end_cnt);
    last_o  = bit_vld_i && !clear_i && at_end;
    cnt_d   = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (bit_vld_i) begin
      cnt_d = at_end ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/owcrc_frame_checker.sv
module owcrc_frame_checker
  import owcrc_pkg::*;
#(
  parameter int unsigned      W        = CRC_W,
  parameter logic [W-1:0]     POLY     = POLY_REFL,
  parameter int unsigned      LEN_ID   = ID_BITS,
  parameter int unsigned      LEN_PAD  = PAD_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         frame_sel_i,
  input  logic         bit_vld_i,
  input  logic         bit_i,
  output logic [W-1:0] rem_o,
  output logic         zero_o,
  output logic         done_o,
  output logic         pass_o,
  output logic         fail_o
);
  logic         rst_int_n;
  logic [W-1:0] rem_next;
  logic         last_bit;
  logic         done_q;
  logic         pass_q;
  logic         done_d;
  logic         pass_d;

  owcrc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  owcrc_serial_core #(.W(W), .POLY(POLY)) u_core (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clear_i    (clear_i),
    .bit_vld_i  (bit_vld_i),
    .bit_i      (bit_i),
    .rem_o      (rem_o),
    .rem_next_o (rem_next)
  );

  owcrc_bit_counter #(.LEN_A(LEN_ID), .LEN_B(LEN_PAD)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clear_i   (clear_i),
    .sel_i     (frame_sel_i == FRAME_PAD),
    .bit_vld_i (bit_vld_i),
    .last_o    (last_bit)
  );

  always_comb begin
    done_d = last_bit;
    pass_d = last_bit && (rem_next == '0);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      done_q <= done_d;
      pass_q <= pass_d;
    end
  end

  assign zero_o = (rem_o == '0);
  assign done_o = done_q;
  assign pass_o = pass_q;
  assign fail_o = done_q & ~pass_q;
endmodule

// File: rtl/owcrc_frame_checker_sva.sv
module owcrc_frame_checker_sva #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clear_i,
  input logic         bit_vld_i,
  input logic [W-1:0] rem_o,
  input logic         zero_o,
  input logic         done_o,
  input logic         pass_o,
  input logic         fail_o
);
  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (rem_o == '0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !bit_vld_i) |=> $stable(rem_o));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass_o, fail_o}) && ((pass_o || fail_o) == done_o));

  // R8
  pass_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> zero_o);
endmodule

bind owcrc_frame_checker owcrc_frame_checker_sva #(.W(W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .clear_i   (clear_i),
  .bit_vld_i (bit_vld_i),
  .rem_o     (rem_o),
  .zero_o    (zero_o),
  .done_o    (done_o),
  .pass_o    (pass_o),
  .fail_o    (fail_o)
);

// File: tb/owcrc_frame_checker_tb.sv
`timescale 1ns/1ps
module owcrc_frame_checker_tb_top;
  logic       clk;
  logic       rst_n;
  logic       clear_i;
  logic       frame_sel_i;
  logic       bit_vld_i;
  logic       bit_i;
  logic [7:0] rem_o;
  logic       zero_o;
  logic       done_o;
  logic       pass_o;
  logic       fail_o;

  int checks;
  int errors;
  bit finished;

  owcrc_frame_checker dut_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .frame_sel_i(frame_sel_i),
    .bit_vld_i(bit_vld_i), .bit_i(bit_i), .rem_o(rem_o), .zero_o(zero_o),
    .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] ref_step(input logic [7:0] r, input logic b);
    logic [7:0] n;
    n = {1'b0, r[7:1]};
    if (b ^ r[0]) n = n ^ 8'h8C;
    return n;
  endfunction

  function automatic logic [7:0] ref_crc(input logic [63:0] v, input int nbits);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < nbits; i++) r = ref_step(r, v[i]);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic shift(input logic b);
    bit_vld_i = 1'b1;
    bit_i     = b;
    @(negedge clk);
    bit_vld_i = 1'b0;
  endtask

  task automatic do_clear();
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
  endtask

  task automatic id_frame(input logic [55:0] data, input int flip);
    logic [63:0] fr;
    fr = {ref_crc({8'h00, data}, 56), data};
    if (flip >= 0) fr[flip] = ~fr[flip];
    frame_sel_i = 1'b0;
    for (int i = 0; i < 64; i++) begin
      shift(fr[i]);
      if (i == 55 && flip < 0) chk("R9 crc after 56 bits", rem_o, fr[63:56]);
      if (i == 62) chk("R6 no done before 64th bit", done_o, 1'b0);
    end
    chk("R6 done after 64 bits", done_o, 1'b1);
    chk("R8 pass", pass_o, flip < 0);
    chk("R8 fail", fail_o, flip >= 0);
    if (flip < 0) chk("R9 zero residue", zero_o, 1'b1);
  endtask

  task automatic pad_frame(input logic [63:0] data, input int flip);
    logic [71:0] fr;
    fr = {ref_crc(data, 64), data};
    if (flip >= 0) fr[flip] = ~fr[flip];
    frame_sel_i = 1'b1;
    for (int i = 0; i < 72; i++) begin
      shift(fr[i]);
      if (i == 63) chk("R7 no done at 64 bits", done_o, 1'b0);
    end
    chk("R7 done after 72 bits", done_o, 1'b1);
    chk("R8 pass pad", pass_o, flip < 0);
    chk("R8 fail pad", fail_o, flip >= 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] lfsr;
    logic [7:0]  exp_r;
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; clear_i = 1'b0; frame_sel_i = 1'b0; bit_vld_i = 1'b0; bit_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rem in reset", rem_o, 8'h00);
    chk("R1 done in reset", {done_o, pass_o, fail_o}, 3'b000);
    rst_n = 1'b1;
    bit_vld_i = 1'b1; bit_i = 1'b1;
    @(negedge clk);
    chk("R1 held during sync release", rem_o, 8'h00);
    bit_vld_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 rem after release", rem_o, 8'h00);
    chk("R5 zero after reset", zero_o, 1'b1);

    // R2 and R5: sweep of all single bytes
    for (int v = 0; v < 256; v++) begin
      do_clear();
      exp_r = 8'h00;
      for (int i = 0; i < 8; i++) begin
        shift(v[i]);
        exp_r = ref_step(exp_r, v[i]);
        chk("R2 remainder step", rem_o, exp_r);
      end
      chk("R5 zero flag", zero_o, exp_r == 8'h00);
    end

    // R3: idle cycles hold value
    do_clear();
    shift(1'b1); shift(1'b0); shift(1'b1);
    exp_r = rem_o;
    repeat (5) @(negedge clk);
    chk("R3 hold without enable", rem_o, exp_r);

    // R4: clear wins over a bit at the same edge
    bit_vld_i = 1'b1; bit_i = 1'b1; clear_i = 1'b1;
    @(negedge clk);
    bit_vld_i = 1'b0; clear_i = 1'b0;
    chk("R4 clear priority", rem_o, 8'h00);

    // R4: counter restarted by clear: 60 bits, clear, then full frame aligned
    frame_sel_i = 1'b0;
    for (int i = 0; i < 60; i++) shift(1'b1);
    do_clear();
    chk("R4 no done from clear", done_o, 1'b0);

    lfsr = 64'h0123_4567_89AB_CDEF;
    for (int k = 0; k < 6; k++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]} ^ (lfsr << 7);
      do_clear();
      id_frame(lfsr[55:0], -1);
      do_clear();
      id_frame(lfsr[55:0], (k * 11) % 64);
      do_clear();
      pad_frame(lfsr, -1);
      do_clear();
      pad_frame(lfsr, (k * 13) % 72);
    end

    // R10: back-to-back frames without clear
    do_clear();
    id_frame(56'h00_1122_3344_5566, -1);
    id_frame(56'hA5_5A5A_0F0F_F0F0, -1);
    chk("R10 second frame counted", done_o, 1'b1);
    shift(1'b0);
    chk("R6 done one cycle only", done_o, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule